// File: doc/BRIEF.md
# PLL Coarse-Band Auto-Calibration Controller

This block selects the coarse tuning code of a VCO capacitor bank before the PLL loop is closed. For each trial code it waits a programmable settling time. It then adds up the VCO edges seen over a fixed window of 64 reference cycles and compares the sum with a target derived from the integer and fractional divide ratio. The next code is chosen by binary search.

The VCO output is counted before any division. A front-end edge counter in the VCO domain reports, once per reference cycle, how many VCO edges fell in that cycle. The window sum therefore resolves frequency to 1/64 of the reference. The target is rounded to the nearest integer, which keeps the residual error within half a count, i.e. 2^-7 of the reference frequency.

The binary search settles one code bit per trial. Two further trials then measure the resulting code and its upper neighbour, and the block keeps whichever lies closer to the target. A one-cycle done pulse follows, and a lock request stays high for the loop until the next accepted start. The code is assumed to raise the VCO frequency as it increases.

Top module: `pll_afc_cal`

## Requirements
- R1: While reset is held and after reset is released, `code_o` is midscale (only the MSB set, 32 for a 6-bit code), `done_o` is 0 and `lock_req_o` is 0.
- R2: The target count is 64·N_int + floor((64·N_frac + 2^(F-1)) / 2^F), where F is the fractional width (10). This is the ideal count rounded half up.
- R3: Each trial measures the sum of `vco_edges_i` over exactly 64 consecutive reference cycles after the settling wait. `code_o` does not change during the window.
- R4: The first trial uses the midscale code. Each search step keeps its bit when the count is below the target and clears it otherwise. The final code is the one with the smallest absolute count error over all codes, and the lower code wins a tie (for a monotonic VCO).
- R5: With settle value S, `done_o` rises (B+2)·(S+67) clock edges after the edge that samples the start strobe, where B is the code width. This becomes (B+1)·(S+67) when the search ends on the all-ones code, because that code has no upper neighbour to measure.
- R6: `done_o` is high for exactly one cycle and is accompanied by `lock_req_o`. `lock_req_o` and `code_o` then hold until the next accepted start, which clears `lock_req_o` in the following cycle.
- R7: A start strobe that arrives while a calibration is running has no effect on the result or on its timing.
- R8: The divide ratio and the settle value are captured on the accepted start. Changes to them during a calibration have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| n_int_i | input | 8 | Integer part of the divide ratio |
| n_frac_i | input | 10 | Fractional part of the divide ratio, units of 2^-10 |
| settle_i | input | 8 | Extra settling cycles after each code change |
| vco_edges_i | input | 9 | VCO edges counted during the current reference cycle |
| code_o | output | 6 | Coarse tuning code to the capacitor bank |
| done_o | output | 1 | One-cycle calibration-complete pulse |
| lock_req_o | output | 1 | Request to close the loop; high after completion |

## Verification
Some properties are checked by the assertions on every cycle. These are the single-cycle width of the done pulse, its pairing with the lock request, the hold of the code while the lock request stands, the frozen code during each counting window, and that completion always follows a code-update step. Other behaviour only the bench scenarios can show. This covers the rounded target, the choice of the nearest code including ties and both range ends, the exact latency, and the immunity to a start strobe and to ratio changes arriving mid-calibration. For these the bench runs a linear VCO model with a fractional edge rate.

// File: rtl/afc_pkg.sv
package afc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_COUNT,
        ST_COMPARE,
        ST_UPDATE,
        ST_DONE
    } afc_state_e;

    typedef enum logic [1:0] {
        PH_SEARCH,
        PH_LOWER,
        PH_UPPER
    } afc_phase_e;

endpackage

// File: rtl/afc_target_calc.sv
module afc_target_calc #(
    parameter int NINT_W   = 8,
    parameter int NFRAC_W  = 10,
    parameter int WIN_LOG2 = 6,
    localparam int TGT_W   = NINT_W + WIN_LOG2 + 1,
    localparam int FULL_W  = NINT_W + NFRAC_W + WIN_LOG2 + 1
) (
    input  logic [NINT_W-1:0]  n_int,
    input  logic [NFRAC_W-1:0] n_frac,
    output logic [TGT_W-1:0]   target
);

    logic [FULL_W-1:0] scaled;
    logic [FULL_W-1:0] rounded;

    always_comb begin
        scaled  = FULL_W'({n_int, n_frac}) << WIN_LOG2;
        rounded = scaled + (FULL_W'(1) << (NFRAC_W - 1));
        target  = rounded[NFRAC_W +: TGT_W];
    end

endmodule

// File: rtl/afc_err_calc.sv
module afc_err_calc #(
    parameter int CNT_W = 15,
    parameter int TGT_W = 15,
    localparam int ERR_W = ((CNT_W > TGT_W) ? CNT_W : TGT_W) + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic [TGT_W-1:0] target,
    output logic             below,
    output logic [ERR_W-1:0] abs_err
);

    logic [ERR_W-1:0] c_x;
    logic [ERR_W-1:0] t_x;

    always_comb begin
        c_x     = ERR_W'(count);
        t_x     = ERR_W'(target);
        below   = (c_x < t_x);
        abs_err = below ? (t_x - c_x) : (c_x - t_x);
    end

endmodule

// File: rtl/afc_code_step.sv
module afc_code_step #(
    parameter int CODE_W = 6,
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic [IDX_W-1:0]  idx,
    input  logic              below,
    output logic [CODE_W-1:0] next_code,
    output logic              last_bit
);

    always_comb begin
        next_code = code;
        for (int b = 0; b < CODE_W; b++) begin
            if (b == int'(idx) && !below)
                next_code[b] = 1'b0;
            if (b + 1 == int'(idx))
                next_code[b] = 1'b1;
        end
        last_bit = (idx == '0);
    end

endmodule

// File: rtl/pll_afc_cal.sv
module pll_afc_cal
    import afc_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int NINT_W   = 8,
    parameter int NFRAC_W  = 10,
    parameter int WIN_LOG2 = 6,
    parameter int EDGE_W   = 9,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NINT_W-1:0]   n_int_i,
    input  logic [NFRAC_W-1:0]  n_frac_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [EDGE_W-1:0]   vco_edges_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                done_o,
    output logic                lock_req_o
);

    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam int CNT_W = EDGE_W + WIN_LOG2;
    localparam int TGT_W = NINT_W + WIN_LOG2 + 1;
    localparam int ERR_W = ((CNT_W > TGT_W) ? CNT_W : TGT_W) + 1;
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        afc_state_e          state;
        afc_phase_e          phase;
        logic [CODE_W-1:0]   code;
        logic [IDX_W-1:0]    idx;
        logic [SETTLE_W-1:0] settle_ld;
        logic [SETTLE_W-1:0] settle_cnt;
        logic [WIN_LOG2-1:0] win_cnt;
        logic [CNT_W-1:0]    acc;
        logic [TGT_W-1:0]    tgt;
        logic                below;
        logic [ERR_W-1:0]    err;
        logic [CODE_W-1:0]   lo_code;
        logic [ERR_W-1:0]    lo_err;
        logic                lock;
    } cal_t;

    cal_t cal_d, cal_q;

    logic [TGT_W-1:0]  tgt_w;
    logic              below_w;
    logic [ERR_W-1:0]  abs_w;
    logic [CODE_W-1:0] step_code_w;
    logic              last_bit_w;
    afc_state_e        st_q;

    afc_target_calc #(
        .NINT_W   (NINT_W),
        .NFRAC_W  (NFRAC_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_target (
        .n_int  (n_int_i),
        .n_frac (n_frac_i),
        .target (tgt_w)
    );

    afc_err_calc #(
        .CNT_W (CNT_W),
        .TGT_W (TGT_W)
    ) u_err (
        .count   (cal_q.acc),
        .target  (cal_q.tgt),
        .below   (below_w),
        .abs_err (abs_w)
    );

    afc_code_step #(
        .CODE_W (CODE_W)
    ) u_step (
        .code      (cal_q.code),
        .idx       (cal_q.idx),
        .below     (cal_q.below),
        .next_code (step_code_w),
        .last_bit  (last_bit_w)
    );

    always_comb begin
        cal_d = cal_q;
        unique case (cal_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    cal_d.code       = MID_CODE;
                    cal_d.idx        = IDX_W'(CODE_W - 1);
                    cal_d.phase      = PH_SEARCH;
                    cal_d.settle_ld  = settle_i;
                    cal_d.settle_cnt = settle_i;
                    cal_d.tgt        = tgt_w;
                    cal_d.lock       = 1'b0;
                    cal_d.state      = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (cal_q.settle_cnt == '0) begin
                    cal_d.win_cnt = '0;
                    cal_d.acc     = '0;
                    cal_d.state   = ST_COUNT;
                end else begin
                    cal_d.settle_cnt = cal_q.settle_cnt - SETTLE_W'(1);
                end
            end
            ST_COUNT: begin
                cal_d.acc     = cal_q.acc + CNT_W'(vco_edges_i);
                cal_d.win_cnt = cal_q.win_cnt + WIN_LOG2'(1);
                if (&cal_q.win_cnt)
                    cal_d.state = ST_COMPARE;
            end
            ST_COMPARE: begin
                cal_d.below = below_w;
                cal_d.err   = abs_w;
                cal_d.state = ST_UPDATE;
            end
            ST_UPDATE: begin
                cal_d.settle_cnt = cal_q.settle_ld;
                cal_d.state      = ST_SETTLE;
                unique case (cal_q.phase)
                    PH_SEARCH: begin
                        cal_d.code = step_code_w;
                        if (last_bit_w)
                            cal_d.phase = PH_LOWER;
                        else
                            cal_d.idx = cal_q.idx - IDX_W'(1);
                    end
                    PH_LOWER: begin
                        cal_d.lo_code = cal_q.code;
                        cal_d.lo_err  = cal_q.err;
                        if (&cal_q.code) begin
                            cal_d.lock  = 1'b1;
                            cal_d.state = ST_DONE;
                        end else begin
                            cal_d.code  = cal_q.code + CODE_W'(1);
                            cal_d.phase = PH_UPPER;
                        end
                    end
                    default: begin
                        if (!(cal_q.err < cal_q.lo_err))
                            cal_d.code = cal_q.lo_code;
                        cal_d.lock  = 1'b1;
                        cal_d.state = ST_DONE;
                    end
                endcase
            end
            default: begin
                cal_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q            <= '0;
            cal_q.state      <= ST_IDLE;
            cal_q.phase      <= PH_SEARCH;
            cal_q.code       <= MID_CODE;
        end else begin
            cal_q <= cal_d;
        end
    end

    assign st_q       = cal_q.state;
    assign code_o     = cal_q.code;
    assign done_o     = (st_q == ST_DONE);
    assign lock_req_o = cal_q.lock;

endmodule

// File: rtl/afc_cal_chk.sv
module afc_cal_chk
    import afc_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              done_o,
    input logic              lock_req_o,
    input logic [CODE_W-1:0] code_o,
    input afc_state_e        st_q
);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> lock_req_o);

    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_req_o && !start_i) |=> $stable(code_o));

    // R3
    window_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT) |=> $stable(code_o));

    // R5
    done_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UPDATE && !done_o) |=> (st_q == ST_SETTLE || done_o));

endmodule

bind pll_afc_cal afc_cal_chk #(.CODE_W(CODE_W)) u_afc_cal_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_o     (done_o),
    .lock_req_o (lock_req_o),
    .code_o     (code_o),
    .st_q       (st_q)
);

// File: tb/pll_afc_cal_test.sv
module pll_afc_cal_test;

    typedef struct packed {
        logic [7:0]  nint;
        logic [9:0]  frac;
        logic [15:0] base;
        logic [7:0]  step;
        logic [7:0]  settle;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'd100, 10'd0,    16'd5000, 8'd40,  8'd0},
        '{8'd80,  10'd512,  16'd4000, 8'd37,  8'd3},
        '{8'd50,  10'd0,    16'd4000, 8'd37,  8'd2},
        '{8'd200, 10'd0,    16'd4000, 8'd37,  8'd1},
        '{8'd70,  10'd8,    16'd4441, 8'd1,   8'd0},
        '{8'd70,  10'd7,    16'd4441, 8'd1,   8'd5},
        '{8'd67,  10'd272,  16'd4000, 8'd10,  8'd4},
        '{8'd255, 10'd1023, 16'd4000, 8'd100, 8'd10}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] n_int_i = '0;
    logic [9:0] n_frac_i = '0;
    logic [7:0] settle_i = '0;
    logic [8:0] vco_edges_i = '0;
    logic [5:0] code_o;
    logic       done_o;
    logic       lock_req_o;

    int checks = 0;
    int errors = 0;
    int m_base = 4000;
    int m_step = 10;
    int facc = 0;

    always #2.5 clk = ~clk;

    pll_afc_cal uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .n_int_i     (n_int_i),
        .n_frac_i    (n_frac_i),
        .settle_i    (settle_i),
        .vco_edges_i (vco_edges_i),
        .code_o      (code_o),
        .done_o      (done_o),
        .lock_req_o  (lock_req_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int vco_count(input int c);
        return m_base + m_step * c;
    endfunction

    // VCO model: a fractional edge rate, so any 64 cycles hold exactly the model count
    initial begin
        forever begin
            int tmp;
            @(negedge clk);
            tmp = facc + vco_count(int'(code_o));
            vco_edges_i = 9'(tmp / 64);
            facc = tmp % 64;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_cal(input vec_t v, input bit disturb, input string tag);
        int tgt, best, best_err, sc, trials, n;
        m_base = int'(v.base);
        m_step = int'(v.step);
        tgt = int'(v.nint) * 64 + (int'(v.frac) * 64 + 512) / 1024;
        best = 0;
        best_err = (vco_count(0) > tgt) ? vco_count(0) - tgt : tgt - vco_count(0);
        sc = 0;
        for (int c = 0; c < 64; c++) begin
            int e;
            e = (vco_count(c) > tgt) ? vco_count(c) - tgt : tgt - vco_count(c);
            if (e < best_err) begin
                best_err = e;
                best = c;
            end
            if (vco_count(c) < tgt) sc = c;
        end
        trials = (sc == 63) ? 7 : 8;

        @(negedge clk);
        n_int_i  = v.nint;
        n_frac_i = v.frac;
        settle_i = v.settle;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        chk({tag, " R6 lock request cleared by start"}, int'(lock_req_o), 0);
        chk({tag, " R4 first trial at midscale"}, int'(code_o), 32);
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
            if (disturb && n == 100) begin
                start_i  = 1'b1;
                n_int_i  = ~v.nint;
                n_frac_i = '0;
                settle_i = 8'd0;
            end else if (disturb && n == 101) begin
                start_i = 1'b0;
            end
        end
        chk({tag, " R5 latency to done"}, n, 1 + trials * (int'(v.settle) + 67));
        chk({tag, " R2 R3 R4 chosen code"}, int'(code_o), best);
        chk({tag, " R6 lock request with done"}, int'(lock_req_o), 1);
        @(negedge clk);
        chk({tag, " R6 done lasts one cycle"}, int'(done_o), 0);
        repeat (5) @(negedge clk);
        chk({tag, " R6 code holds"}, int'(code_o), best);
        chk({tag, " R6 lock request holds"}, int'(lock_req_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: during reset
        chk("R1 code in reset", int'(code_o), 32);
        chk("R1 done in reset", int'(done_o), 0);
        chk("R1 lock in reset", int'(lock_req_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 code after reset", int'(code_o), 32);
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 lock after reset", int'(lock_req_o), 0);

        // table walk: R2 rounding cases (vectors 4, 5), R4 range ends and tie (2, 3, 6)
        for (int i = 0; i < NVEC; i++) begin
            run_cal(VECS[i], 1'b0, $sformatf("vec%0d", i));
        end

        // R7 and R8: mid-calibration start strobe plus ratio and settle changes
        run_cal(VECS[1], 1'b1, "R7 R8 disturbed");
        run_cal(VECS[6], 1'b1, "R7 R8 disturbed tie");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule